// File: doc/BRIEF.md
# PPP/HDLC Transmit Packet Encapsulator

This block drains outbound packets from the read side of a transmit FIFO and turns them into an unbroken octet stream for a downstream DS3/E3 framer. The FIFO side is either 8 or 16 bits wide. Each popped unit carries a start marker, an end marker, an odd-length marker and one parity bit. The block checks the parity of every unit and splits 16-bit words into octets. It escapes the two reserved octet values and closes each packet with a CRC-16 or CRC-32 frame check sequence. Whenever it has no packet data to send, it fills the line with flag octets.

The output is one octet per accepted cycle. The octet on `tx_data_o` is taken when `tx_ready_i` is high at a rising clock edge, and the block holds everything while ready is low. A parity mismatch produces a one-cycle pulse and bumps a saturating counter. The packet itself is sent unchanged. The data width, the CRC choice and the parity sense are static inputs, and they are changed only while no packet is in flight. The CRC choice is latched when each packet starts.

Top module: `ppp_tx_encap`

## Requirements
- R1: Out of reset, and whenever no packet is being sent, `tx_data_o` carries the flag octet 0x7E on every accepted cycle.
- R2: A payload or check octet of value 0x7E goes out as 0x7D followed by 0x5E.
- R3: A payload or check octet of value 0x7D goes out as 0x7D followed by 0x5D.
- R4: Each packet is followed by its frame check sequence. With `crc32_i`=1 this is CRC-32 (reflected poly 0xEDB88320), 4 octets. With `crc32_i`=0 it is CRC-16 (reflected poly 0x8408), 2 octets. Both start from all ones, cover the unescaped payload, are sent complemented, and go out least significant octet first. The check octets pass through the same escaping as the payload.
- R5: After the last check octet of a packet, the next octet is 0x7E. One flag may both close one packet and open the next.
- R6: With `wide_i`=1, each 16-bit word is sent as bits [15:8] first, then bits [7:0]. On an end-marked word with `fifo_odd_i`=1, only bits [15:8] are sent. With `wide_i`=0, only bits [7:0] of each unit are used.
- R7: Parity is checked per popped unit over 8 bits (`wide_i`=0) or 16 bits (`wide_i`=1) together with `fifo_par_i`. `par_odd_i`=1 expects an odd count of ones and 0 expects an even count. A mismatch raises `par_err_o` for exactly the one cycle after the pop edge.
- R8: `err_cnt_o` resets to 0, increments on each `par_err_o` pulse and saturates at all ones (65535 by default).
- R9: While `tx_ready_i` is low, `tx_data_o` holds its value and no unit is popped. This also holds between the two octets of an escape pair.
- R10: While idle, a unit without the start marker is popped and dropped; no octet of it reaches the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wide_i | input | 1 | 1: 16-bit units, 0: 8-bit units |
| crc32_i | input | 1 | 1: CRC-32 trailer, 0: CRC-16 trailer |
| par_odd_i | input | 1 | 1: odd parity expected, 0: even |
| fifo_valid_i | input | 1 | FIFO holds a unit |
| fifo_data_i | input | 16 | FIFO head unit |
| fifo_sop_i | input | 1 | Head unit starts a packet |
| fifo_eop_i | input | 1 | Head unit ends a packet |
| fifo_odd_i | input | 1 | End unit has only its upper octet valid |
| fifo_par_i | input | 1 | Parity bit of the head unit |
| fifo_rd_o | output | 1 | Pop the head unit at this edge |
| tx_data_o | output | 8 | Output octet |
| tx_ready_i | input | 1 | Downstream takes `tx_data_o` at this edge |
| par_err_o | output | 1 | Parity mismatch pulse |
| err_cnt_o | output | ERR_W | Saturating parity error count |

## Verification
A pop at a rising edge shows its parity result on `par_err_o` and `err_cnt_o` right after that same edge. The bench records the pop at the falling edge before it and compares both outputs at the next falling edge. An octet is counted as sent only when ready was high at the falling edge before the edge that takes it. The bench matches the sent octets, in order, against a queue of escaped frames built from the packet bytes and a bit-serial CRC model, with known check values for the ASCII string "123456789". While ready is low, every falling edge is used to confirm that the octet held and that nothing was popped.

// File: rtl/ppp_tx_pkg.sv
package ppp_tx_pkg;
  localparam int unsigned OCT_W = 8;
  localparam int unsigned UNIT_W = 2 * OCT_W;
  localparam logic [OCT_W-1:0] FLAG_OCT = 8'h7E;
  localparam logic [OCT_W-1:0] ESC_OCT = 8'h7D;
  localparam logic [OCT_W-1:0] ESC_MASK = 8'h20;
  localparam logic [31:0] POLY32_R = 32'hEDB88320;
  localparam logic [15:0] POLY16_R = 16'h8408;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_FCS  = 2'd2
  } tx_st_e;

  // reflected, LSB-first byte update; 16-bit mode lives in bits [15:0]
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b,
                                           input logic is32);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < OCT_W; i++) begin
      if (is32) r = (r[0] ^ b[i]) ? ((r >> 1) ^ POLY32_R) : (r >> 1);
      else r = {16'h0000, (r[0] ^ b[i]) ? ((r[15:0] >> 1) ^ POLY16_R) : (r[15:0] >> 1)};
    end
    return r;
  endfunction
endpackage

// File: rtl/ppp_tx_split.sv
module ppp_tx_split
  import ppp_tx_pkg::*;
#(
  parameter int unsigned ERR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_i,
  input  logic              par_odd_i,
  input  logic              ready_i,
  input  logic              fifo_valid_i,
  input  logic [UNIT_W-1:0] fifo_data_i,
  input  logic              fifo_sop_i,
  input  logic              fifo_eop_i,
  input  logic              fifo_odd_i,
  input  logic              fifo_par_i,
  output logic              fifo_rd_o,
  input  logic              take_i,
  output logic              oct_valid_o,
  output logic [OCT_W-1:0]  oct_o,
  output logic              oct_sop_o,
  output logic              oct_eop_o,
  output logic              par_err_o,
  output logic [ERR_W-1:0]  err_cnt_o
);
  logic [1:0]        cnt_q;
  logic [UNIT_W-1:0] buf_q;
  logic              sop_q, eop_q;
  logic              perr_q;
  logic [ERR_W-1:0]  ecnt_q;
  logic              unit_bad;

  // refill when empty, or when the last held octet leaves this cycle
  assign fifo_rd_o = ready_i && fifo_valid_i &&
                     ((cnt_q == 2'd0) || ((cnt_q == 2'd1) && take_i));

  assign oct_valid_o = (cnt_q != 2'd0);
  assign oct_o       = (cnt_q == 2'd2) ? buf_q[UNIT_W-1:OCT_W] : buf_q[OCT_W-1:0];
  assign oct_sop_o   = sop_q;
  assign oct_eop_o   = eop_q && (cnt_q == 2'd1);

  assign unit_bad = (wide_i ? (^fifo_data_i) : (^fifo_data_i[OCT_W-1:0]))
                    ^ fifo_par_i ^ par_odd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= 2'd0;
      buf_q <= '0;
      sop_q <= 1'b0;
      eop_q <= 1'b0;
    end else if (fifo_rd_o) begin
      sop_q <= fifo_sop_i;
      eop_q <= fifo_eop_i;
      if (!wide_i) begin
        buf_q <= {{OCT_W{1'b0}}, fifo_data_i[OCT_W-1:0]};
        cnt_q <= 2'd1;
      end else if (fifo_eop_i && fifo_odd_i) begin
        buf_q <= {{OCT_W{1'b0}}, fifo_data_i[UNIT_W-1:OCT_W]};
        cnt_q <= 2'd1;
      end else begin
        buf_q <= fifo_data_i;
        cnt_q <= 2'd2;
      end
    end else if (take_i && (cnt_q != 2'd0)) begin
      cnt_q <= cnt_q - 2'd1;
      sop_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      perr_q <= 1'b0;
      ecnt_q <= '0;
    end else begin
      perr_q <= fifo_rd_o && unit_bad;
      if (fifo_rd_o && unit_bad && !(&ecnt_q)) ecnt_q <= ecnt_q + ERR_W'(1);
    end
  end

  assign par_err_o = perr_q;
  assign err_cnt_o = ecnt_q;
endmodule

// File: rtl/ppp_tx_crc.sv
module ppp_tx_crc
  import ppp_tx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             sel32_i,
  input  logic             upd_i,
  input  logic [OCT_W-1:0] byte_i,
  output logic             sel32_o,
  output logic [31:0]      fcs_o
);
  logic [31:0] crc_q;
  logic        sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q <= '1;
      sel_q <= 1'b0;
    end else if (init_i) begin
      crc_q <= sel32_i ? 32'hFFFF_FFFF : 32'h0000_FFFF;
      sel_q <= sel32_i;
    end else if (upd_i) begin
      crc_q <= crc_step(crc_q, byte_i, sel_q);
    end
  end

  assign sel32_o = sel_q;
  assign fcs_o   = sel_q ? ~crc_q : {16'h0000, ~crc_q[15:0]};
endmodule

// File: rtl/ppp_tx_encap.sv
module ppp_tx_encap
  import ppp_tx_pkg::*;
#(
  parameter int unsigned ERR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wide_i,
  input  logic             crc32_i,
  input  logic             par_odd_i,
  input  logic             fifo_valid_i,
  input  logic [15:0]      fifo_data_i,
  input  logic             fifo_sop_i,
  input  logic             fifo_eop_i,
  input  logic             fifo_odd_i,
  input  logic             fifo_par_i,
  output logic             fifo_rd_o,
  output logic [7:0]       tx_data_o,
  input  logic             tx_ready_i,
  output logic             par_err_o,
  output logic [ERR_W-1:0] err_cnt_o
);
  tx_st_e           st_q, st_d;
  logic [OCT_W-1:0] out_q, out_d;
  logic             esc_q, esc_d;
  logic [OCT_W-1:0] escb_q, escb_d;
  logic [1:0]       idx_q, idx_d;

  logic             take;
  logic             oct_valid, oct_sop, oct_eop;
  logic [OCT_W-1:0] oct;
  logic             crc_init, crc_upd, sel32;
  logic [31:0]      fcs;
  logic [OCT_W-1:0] fcs_oct;
  logic             fcs_last;

  ppp_tx_split #(.ERR_W(ERR_W)) u_split (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wide_i       (wide_i),
    .par_odd_i    (par_odd_i),
    .ready_i      (tx_ready_i),
    .fifo_valid_i (fifo_valid_i),
    .fifo_data_i  (fifo_data_i),
    .fifo_sop_i   (fifo_sop_i),
    .fifo_eop_i   (fifo_eop_i),
    .fifo_odd_i   (fifo_odd_i),
    .fifo_par_i   (fifo_par_i),
    .fifo_rd_o    (fifo_rd_o),
    .take_i       (take),
    .oct_valid_o  (oct_valid),
    .oct_o        (oct),
    .oct_sop_o    (oct_sop),
    .oct_eop_o    (oct_eop),
    .par_err_o    (par_err_o),
    .err_cnt_o    (err_cnt_o)
  );

  ppp_tx_crc u_crc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .init_i  (crc_init),
    .sel32_i (crc32_i),
    .upd_i   (crc_upd),
    .byte_i  (oct),
    .sel32_o (sel32),
    .fcs_o   (fcs)
  );

  always_comb begin
    unique case (idx_q)
      2'd0:    fcs_oct = fcs[7:0];
      2'd1:    fcs_oct = fcs[15:8];
      2'd2:    fcs_oct = fcs[23:16];
      default: fcs_oct = fcs[31:24];
    endcase
  end

  assign fcs_last = sel32 ? (idx_q == 2'd3) : (idx_q == 2'd1);

  always_comb begin
    st_d     = st_q;
    out_d    = out_q;
    esc_d    = esc_q;
    escb_d   = escb_q;
    idx_d    = idx_q;
    take     = 1'b0;
    crc_init = 1'b0;
    crc_upd  = 1'b0;
    if (tx_ready_i) begin
      if (esc_q) begin
        out_d = escb_q ^ ESC_MASK;
        esc_d = 1'b0;
      end else begin
        unique case (st_q)
          ST_IDLE: begin
            out_d = FLAG_OCT;
            if (oct_valid) begin
              if (oct_sop) begin
                st_d     = ST_DATA;
                crc_init = 1'b1;
              end else begin
                take = 1'b1;  // stray unit outside a packet
              end
            end
          end
          ST_DATA: begin
            if (oct_valid) begin
              take    = 1'b1;
              crc_upd = 1'b1;
              if (oct == FLAG_OCT || oct == ESC_OCT) begin
                out_d  = ESC_OCT;
                esc_d  = 1'b1;
                escb_d = oct;
              end else begin
                out_d = oct;
              end
              if (oct_eop) begin
                st_d  = ST_FCS;
                idx_d = 2'd0;
              end
            end else begin
              out_d = FLAG_OCT;
            end
          end
          ST_FCS: begin
            if (fcs_oct == FLAG_OCT || fcs_oct == ESC_OCT) begin
              out_d  = ESC_OCT;
              esc_d  = 1'b1;
              escb_d = fcs_oct;
            end else begin
              out_d = fcs_oct;
            end
            idx_d = idx_q + 2'd1;
            if (fcs_last) st_d = ST_IDLE;
          end
          default: begin
            st_d  = ST_IDLE;
            out_d = FLAG_OCT;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      out_q  <= FLAG_OCT;
      esc_q  <= 1'b0;
      escb_q <= '0;
      idx_q  <= 2'd0;
    end else begin
      st_q   <= st_d;
      out_q  <= out_d;
      esc_q  <= esc_d;
      escb_q <= escb_d;
      idx_q  <= idx_d;
    end
  end

  assign tx_data_o = out_q;
endmodule

// File: rtl/ppp_tx_encap_chk.sv
module ppp_tx_encap_chk #(
  parameter int unsigned ERR_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fifo_valid_i,
  input logic             fifo_rd_o,
  input logic [7:0]       tx_data_o,
  input logic             tx_ready_i,
  input logic             par_err_o,
  input logic [ERR_W-1:0] err_cnt_o
);
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_ready_i |=> $stable(tx_data_o)); // R9
  AST_STALL_NO_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_ready_i |-> !fifo_rd_o); // R9
  AST_ESC_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ready_i && tx_data_o == 8'h7D) |=> (tx_data_o == 8'h5E || tx_data_o == 8'h5D)); // R2
  AST_POP_HAS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_o |-> fifo_valid_i); // R10
  AST_PERR_AFTER_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_err_o |-> $past(fifo_rd_o)); // R7
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_err_o |-> (err_cnt_o == $past(err_cnt_o) + ERR_W'(1)) || (&$past(err_cnt_o))); // R8
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !par_err_o |-> $stable(err_cnt_o)); // R8
endmodule

bind ppp_tx_encap ppp_tx_encap_chk #(.ERR_W(ERR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fifo_valid_i (fifo_valid_i),
  .fifo_rd_o    (fifo_rd_o),
  .tx_data_o    (tx_data_o),
  .tx_ready_i   (tx_ready_i),
  .par_err_o    (par_err_o),
  .err_cnt_o    (err_cnt_o)
);

// File: tb/ppp_tx_encap_test.sv
module ppp_tx_encap_test;
  localparam int ERR_W = 16;
  localparam int SAT = (1 << ERR_W) - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, wide, crc32, podd;
  logic fvalid, fsop, feop, fodd, fpar, frd;
  logic [15:0] fdata;
  logic [7:0] txd;
  logic rdy, perr;
  logic [ERR_W-1:0] ecnt;

  ppp_tx_encap #(.ERR_W(ERR_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wide_i(wide), .crc32_i(crc32), .par_odd_i(podd),
    .fifo_valid_i(fvalid), .fifo_data_i(fdata), .fifo_sop_i(fsop), .fifo_eop_i(feop),
    .fifo_odd_i(fodd), .fifo_par_i(fpar), .fifo_rd_o(frd), .tx_data_o(txd),
    .tx_ready_i(rdy), .par_err_o(perr), .err_cnt_o(ecnt)
  );

  typedef struct {
    logic [15:0] d;
    logic sop, eop, odd, par, bad;
  } unit_t;

  unit_t fq[$];
  logic [7:0] exp_q[$];
  int flen_q[$];

  int checks = 0, errors = 0;
  int rmode = 0;
  bit mon_on = 0, pend_pop = 0, exp_perr = 0;
  int exp_cnt = 0;
  bit in_frame = 0, need_flag = 0, prev_was_esc = 0;
  int rem = 0, frames_rx = 0, frames_tx = 0;
  logic prev_rdy = 1'b1;
  logic [7:0] prev_out = 8'h7E;
  string stag = "R4";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_fcs(input logic [7:0] p[$], input bit c32);
    logic [31:0] c;
    bit fb;
    c = c32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    foreach (p[i]) begin
      for (int k = 0; k < 8; k++) begin
        fb = c[0] ^ p[i][k];
        c = c >> 1;
        if (fb) c = c ^ (c32 ? 32'hEDB88320 : 32'h00008408);
      end
    end
    return c32 ? ~c : {16'h0000, ~c[15:0]};
  endfunction

  task automatic send_pkt(input logic [7:0] p[$], input bit w, input bit c32, input bit po,
                          input int bad_u, input bit known, input logic [31:0] kfcs);
    logic [31:0] f;
    logic [7:0] fr[$];
    int len;
    int nu;
    int i;
    unit_t u;
    logic [15:0] bits;
    f = known ? kfcs : ref_fcs(p, c32);
    fr = p;
    for (int k = 0; k < (c32 ? 4 : 2); k++) fr.push_back(f[8*k +: 8]);
    len = 0;
    foreach (fr[k]) begin
      if (fr[k] == 8'h7E || fr[k] == 8'h7D) begin
        exp_q.push_back(8'h7D);
        exp_q.push_back(fr[k] ^ 8'h20);
        len += 2;
      end else begin
        exp_q.push_back(fr[k]);
        len += 1;
      end
    end
    flen_q.push_back(len);
    frames_tx++;
    nu = 0;
    i = 0;
    while (i < p.size()) begin
      if (!w) begin u.d = {8'h00, p[i]}; i++; end
      else if (i + 1 < p.size()) begin u.d = {p[i], p[i+1]}; i += 2; end
      else begin u.d = {p[i], 8'h00}; i++; end
      u.sop = (nu == 0);
      u.eop = (i >= p.size());
      u.odd = w && u.eop && (p.size() % 2 == 1);
      bits = w ? u.d : {8'h00, u.d[7:0]};
      u.bad = (nu == bad_u);
      u.par = (^bits) ^ po ^ u.bad;
      fq.push_back(u);
      nu++;
    end
  endtask

  task automatic gen(output logic [7:0] p[$], input int n);
    p = {};
    for (int k = 0; k < n; k++) begin
      if ($urandom % 4 == 0) p.push_back(($urandom % 2) ? 8'h7E : 8'h7D);
      else p.push_back(8'($urandom % 256));
    end
  endtask

  task automatic drain();
    while (fq.size() != 0 || exp_q.size() != 0 || in_frame || need_flag) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic parse(input logic [7:0] o);
    logic [7:0] e;
    if (need_flag) begin
      chk(o == 8'h7E, "R5 flag after frame", o, 8'h7E);
      need_flag = 0;
      return;
    end
    if (!in_frame) begin
      if (o == 8'h7E) return;
      if (flen_q.size() == 0) begin
        chk(0, "R1 octet outside any frame", o, 8'h7E);
        return;
      end
      in_frame = 1;
      rem = flen_q.pop_front();
      prev_was_esc = 0;
    end
    e = exp_q.pop_front();
    if (prev_was_esc && e == 8'h5E) chk(o == e, "R2 escape of 7E", o, e);
    else if (prev_was_esc && e == 8'h5D) chk(o == e, "R3 escape of 7D", o, e);
    else chk(o == e, stag, o, e);
    prev_was_esc = (e == 8'h7D) && !prev_was_esc;
    rem--;
    if (rem == 0) begin
      in_frame = 0;
      need_flag = 1;
      frames_rx++;
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (pend_pop) begin
        fq.delete(0);
        pend_pop = 0;
      end
      if (fq.size() > 0) begin
        fvalid = 1'b1; fdata = fq[0].d; fsop = fq[0].sop; feop = fq[0].eop;
        fodd = fq[0].odd; fpar = fq[0].par;
      end else begin
        fvalid = 1'b0; fdata = '0; fsop = 0; feop = 0; fodd = 0; fpar = 0;
      end
      case (rmode)
        0: rdy = 1'b1;
        default: rdy = ($urandom % 3) != 0;
      endcase
      #1;
      if (exp_perr && exp_cnt < SAT) exp_cnt++;
      chk(perr == exp_perr, "R7 parity pulse", perr, exp_perr);
      chk(ecnt == ERR_W'(exp_cnt), "R8 error count", ecnt, exp_cnt);
      if (!prev_rdy) chk(txd == prev_out, "R9 hold on stall", txd, prev_out);
      if (!rdy) chk(!frd, "R9 no pop on stall", frd, 0);
      exp_perr = frd && fq.size() > 0 && fq[0].bad;
      pend_pop = frd;
      if (rdy) parse(txd);
      prev_rdy = rdy;
      prev_out = txd;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] p[$];
    logic [7:0] kv[$];
    unit_t u;
    rst_n = 0; wide = 0; crc32 = 0; podd = 0; rdy = 1;
    fvalid = 0; fdata = '0; fsop = 0; feop = 0; fodd = 0; fpar = 0;
    repeat (4) @(negedge clk);
    #1;
    chk(txd == 8'h7E, "R1 reset flag", txd, 8'h7E);
    chk(perr == 0, "R7 reset pulse", perr, 0);
    chk(ecnt == 0, "R8 reset count", ecnt, 0);
    chk(frd == 0, "R10 no pop without data", frd, 0);
    @(negedge clk);
    rst_n = 1;
    mon_on = 1;
    repeat (6) @(negedge clk);
    chk(frames_rx == 0 && !in_frame, "R1 idle flags only", frames_rx, 0);

    // known check values, 8-bit units
    kv = {8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    stag = "R4 crc16 known";
    send_pkt(kv, 0, 0, 0, -1, 1, 32'h0000906E);
    drain();
    stag = "R4 escape stream";
    p = {8'h01, 8'h7E, 8'h02, 8'h7D, 8'h7E, 8'h7D, 8'h03};
    send_pkt(p, 0, 0, 0, 2, 0, 0);
    drain();
    crc32 = 1;
    stag = "R4 crc32 known";
    send_pkt(kv, 0, 1, 0, -1, 1, 32'hCBF43926);
    drain();

    // back-to-back random, stalls, CRC-32
    rmode = 1;
    stag = "R4 random crc32";
    for (int n = 0; n < 8; n++) begin
      gen(p, 1 + ($urandom % 20));
      send_pkt(p, 0, 1, 0, (n % 3 == 0) ? n : -1, 0, 0);
    end
    drain();
    crc32 = 0;
    stag = "R4 random crc16";
    for (int n = 0; n < 8; n++) begin
      gen(p, 1 + ($urandom % 20));
      send_pkt(p, 0, 0, 0, -1, 0, 0);
    end
    drain();

    // 16-bit units, odd parity
    wide = 1; podd = 1;
    stag = "R6 wide crc16";
    for (int n = 0; n < 8; n++) begin
      gen(p, 1 + n * 3);
      send_pkt(p, 1, 0, 1, (n % 2 == 1) ? 0 : -1, 0, 0);
    end
    drain();
    crc32 = 1;
    stag = "R6 wide crc32";
    send_pkt(kv, 1, 1, 1, -1, 1, 32'hCBF43926);
    for (int n = 0; n < 6; n++) begin
      gen(p, 2 + ($urandom % 17));
      send_pkt(p, 1, 1, 1, 1, 0, 0);
    end
    drain();
    chk(frames_rx == frames_tx, "R5 every frame delimited", frames_rx, frames_tx);

    // stray units while idle are dropped
    wide = 0; podd = 0; crc32 = 0; rmode = 0;
    for (int n = 0; n < 5; n++) begin
      u.d = 16'h007E; u.sop = 0; u.eop = (n == 4); u.odd = 0; u.bad = (n == 1);
      u.par = (^u.d[7:0]) ^ u.bad;
      fq.push_back(u);
    end
    drain();
    chk(frames_rx == frames_tx && !in_frame, "R10 stray units dropped", frames_rx, frames_tx);
    stag = "R10 packet after strays";
    send_pkt(kv, 0, 0, 0, -1, 1, 32'h0000906E);
    drain();

    // saturate the error counter
    for (int n = 0; n < SAT + 200; n++) begin
      u.d = 16'(n % 256); u.sop = 0; u.eop = 0; u.odd = 0; u.bad = 1;
      u.par = ~(^u.d[7:0]);
      fq.push_back(u);
    end
    drain();
    chk(ecnt == ERR_W'(SAT), "R8 saturation", ecnt, SAT);
    chk(flen_q.size() == 0 && exp_q.size() == 0, "R5 nothing left", flen_q.size(), 0);

    mon_on = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule